// File: doc/BRIEF.md
# DMA Bandwidth Throttle for Bus Requests

This block sits between a DMA channel's raw bus request and the system arbiter. Software selects a block size with a 3-bit bandwidth code. When the channel's decrementing byte counter reaches a multiple of that block size, the block withdraws the bus request. The request stays withdrawn until the bus cycle in flight terminates. During that window the arbiter can hand the bus to another master that is waiting.

Accesses may vary in size, for example when alignment shrinks or grows them. A single counter step can therefore jump past a block multiple without landing on it. To cover this, the block keeps the previous counter value as a reference and checks whether the step spanned a boundary.

A counter that moves to zero is ignored, because the transfer is ending anyway. A step that does not move the counter down is treated as a reload. The block latches the new value as the reference and does not throttle.

Top module: `bw_throttle`

## Requirements
- R1: Bandwidth code 0 disables throttling. Code c from 1 to 7 selects a block size of 2^(13+c) bytes, which gives 16 KiB for code 1 and 1 MiB for code 7.
- R2: `cnt_upd` can be high with a non-zero `cnt_val` that lies below the reference and lands exactly on a multiple of the block size. In that case `bus_req` goes low from the clock edge that samples the strobe.
- R3: An update below the reference may step across a block multiple without landing on it. A multiple m counts as crossed when new value ≤ m < reference. Such an update also drops `bus_req` from that edge.
- R4: An update to a counter value of zero never drops `bus_req`.
- R5: An update whose value is greater than or equal to the reference never drops `bus_req`. That value becomes the new reference.
- R6: Once dropped, `bus_req` stays low until an edge samples `cyc_end` high. From the next edge onward, `bus_req` follows `dma_req` again.
- R7: `bus_req` is never high while `dma_req` is low.
- R8: `cnt_val` has no effect at an edge where `cnt_upd` is low.
- R9: Reset clears the dropped state and sets the reference to zero.
- R10: If an edge sees both a dropping update and `cyc_end`, the request is dropped. A later `cyc_end` releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bw_sel | input | 3 | Bandwidth code (0 = off) |
| cnt_val | input | 24 | Byte counter value after the current update |
| cnt_upd | input | 1 | Counter update strobe |
| dma_req | input | 1 | Raw bus request from the DMA engine |
| cyc_end | input | 1 | Termination of the current bus cycle |
| bus_req | output | 1 | Gated bus request to the arbiter |

## Verification
The bench aims at the boundary arithmetic with several kinds of step:
- **Steps that cross a multiple without landing on it.** A design that only tests for exact multiples would never yield on these.
- **Steps that leave a value sitting exactly on a multiple.** A design that subtracts nothing from the reference would count that boundary a second time.
- **Updates to zero.** The naive modulo test would throttle at the end of every transfer.
- **Upward reloads.** A design that treated them as a crossing would block the first access of a new transfer.

It also covers three timing cases:
- **Release timing.** The request must return on the cycle after termination, not one cycle early or late.
- **A boundary and a termination arriving together.** A wrong set/clear priority would lose the yield.
- **Counter changes without a strobe.** These must leave the request alone.

// File: rtl/bw_throttle.sv
module bw_throttle #(
  parameter int CNT_W     = 24,
  parameter int SEL_W     = 3,
  parameter int BASE_LOG2 = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] bw_sel,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_upd,
  input  logic             dma_req,
  input  logic             cyc_end,
  output logic             bus_req
);
  localparam int LOG_W = $clog2(BASE_LOG2 + (1 << SEL_W) + 1);

  logic [CNT_W-1:0] ref_cnt;
  logic             hold;

  wire [LOG_W-1:0] blk_log   = LOG_W'(BASE_LOG2 - 1) + LOG_W'(bw_sel);
  wire             thr_on    = |bw_sel;
  wire             going_dn  = cnt_val < ref_cnt;
  wire             non_zero  = |cnt_val;
  wire [CNT_W-1:0] blk_new   = (cnt_val - CNT_W'(1)) >> blk_log;
  wire [CNT_W-1:0] blk_old   = (ref_cnt - CNT_W'(1)) >> blk_log;
  wire             crossed   = blk_new != blk_old;
  wire             hit       = cnt_upd & thr_on & going_dn & non_zero & crossed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_cnt <= '0;
      hold    <= 1'b0;
    end else begin
      if (cnt_upd) ref_cnt <= cnt_val;
      if (hit)          hold <= 1'b1;
      else if (cyc_end) hold <= 1'b0;
    end
  end

  assign bus_req = dma_req & ~hold;
endmodule

module bw_throttle_chk #(
  parameter int CNT_W = 24,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEL_W-1:0] bw_sel,
  input logic [CNT_W-1:0] cnt_val,
  input logic             cnt_upd,
  input logic             dma_req,
  input logic             cyc_end,
  input logic             bus_req
);
  AST_NO_REQ_WITHOUT_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_req |-> !bus_req); // R7

  AST_HOLD_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !bus_req && !cyc_end) |=> !bus_req); // R6

  AST_RELEASE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !bus_req && cyc_end && !cnt_upd) |=> (bus_req == dma_req)); // R6

  AST_OFF_NEVER_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bw_sel == '0) |=> (bus_req == dma_req)); // R1

  AST_ZERO_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && cnt_upd && cnt_val == '0) |=> (bus_req == dma_req)); // R4

  AST_NO_STROBE_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !cnt_upd) |=> (bus_req == dma_req)); // R8
endmodule

bind bw_throttle bw_throttle_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bw_sel(bw_sel), .cnt_val(cnt_val),
  .cnt_upd(cnt_upd), .dma_req(dma_req), .cyc_end(cyc_end), .bus_req(bus_req)
);

// File: tb/bw_throttle_test.sv
module bw_throttle_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bw_sel = 3'd0;
  logic [23:0] cnt_val = 24'd0;
  logic        cnt_upd = 1'b0;
  logic        dma_req = 1'b0;
  logic        cyc_end = 1'b0;
  logic        bus_req;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  bw_throttle uut (
    .clk(clk), .rst_n(rst_n), .bw_sel(bw_sel), .cnt_val(cnt_val),
    .cnt_upd(cnt_upd), .dma_req(dma_req), .cyc_end(cyc_end), .bus_req(bus_req)
  );

  // {code, reference, new value, expect drop}
  localparam int NV = 12;
  localparam logic [51:0] VEC [NV] = '{
    {3'd1, 24'h004004, 24'h004000, 1'b1},  // R2 land 16K
    {3'd1, 24'h004003, 24'h003FFF, 1'b1},  // R3 cross 16K
    {3'd1, 24'h004000, 24'h003FFC, 1'b0},  // R3 leaving a multiple
    {3'd1, 24'h005000, 24'h004800, 1'b0},  // R2 inside a block
    {3'd0, 24'h004004, 24'h004000, 1'b0},  // R1 code 0 off
    {3'd2, 24'h004004, 24'h004000, 1'b0},  // R1 32K ignores 16K
    {3'd2, 24'h008002, 24'h007FFE, 1'b1},  // R1 32K cross
    {3'd7, 24'h100001, 24'h0FFFFF, 1'b1},  // R1 1M cross
    {3'd7, 24'h080004, 24'h080000, 1'b0},  // R1 1M ignores 512K
    {3'd1, 24'h000004, 24'h000000, 1'b0},  // R4 zero
    {3'd3, 24'h020010, 24'h01FFF0, 1'b1},  // R3 64K cross
    {3'd1, 24'h003000, 24'h005000, 1'b0}   // R5 upward reload
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: bus_req=%b expected %b", req, act, exp);
    end
  endtask

  task automatic upd(input logic [23:0] v);
    @(negedge clk);
    cnt_val = v;
    cnt_upd = 1'b1;
    @(negedge clk);
    cnt_upd = 1'b0;
  endtask

  task automatic cend();
    @(negedge clk);
    cyc_end = 1'b1;
    @(negedge clk);
    cyc_end = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset no request", bus_req, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 idle after reset", bus_req, 1'b0);
    dma_req = 1'b1;
    #1;
    chk("R9 request passes after reset", bus_req, 1'b1);

    for (int i = 0; i < NV; i++) begin
      bw_sel = VEC[i][51:49];
      upd(24'd0);
      upd(VEC[i][48:25]);
      cend();
      upd(VEC[i][24:1]);
      chk($sformatf("R1/R2/R3/R4/R5 vector %0d", i), bus_req, ~VEC[i][0]);
      cend();
      chk($sformatf("R6 release vector %0d", i), bus_req, 1'b1);
    end

    bw_sel = 3'd1;
    upd(24'd0);
    upd(24'h004004);
    upd(24'h004000);
    repeat (3) @(negedge clk);
    chk("R6 held without termination", bus_req, 1'b0);
    dma_req = 1'b0;
    #1;
    chk("R7 low while dma_req low", bus_req, 1'b0);
    cend();
    chk("R7 stays low after release with dma_req low", bus_req, 1'b0);
    dma_req = 1'b1;
    #1;
    chk("R6 follows dma_req after release", bus_req, 1'b1);

    upd(24'd0);
    upd(24'h004004);
    @(negedge clk);
    cnt_val = 24'h004000;
    repeat (2) @(negedge clk);
    chk("R8 value without strobe ignored", bus_req, 1'b1);

    upd(24'h004004);
    @(negedge clk);
    cnt_val = 24'h004000;
    cnt_upd = 1'b1;
    cyc_end = 1'b1;
    @(negedge clk);
    cnt_upd = 1'b0;
    cyc_end = 1'b0;
    chk("R10 drop wins over termination", bus_req, 1'b0);
    cend();
    chk("R10 later termination releases", bus_req, 1'b1);

    upd(24'h004008);
    upd(24'h004004);
    upd(24'h004000);
    chk("R5 reference tracks steps", bus_req, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R9 reset clears drop", bus_req, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule